// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets synchronous logic read and write an asynchronous 64K x 16 static RAM whose control pins are all active low. The host offers one request at a time on a valid/ready port. Each request carries a read/write flag, a word address, write data and a two-bit lane mask. The controller then plays out the pin sequence for that access. The pins are chip select, output enable, write strobe and one enable per byte lane. The shared data bus is driven through separate out, out-enable and in signals.

The RAM's nanosecond minimums are met by counting clock cycles. Four parameters hold the cycle counts for read access, write strobe width, data lead before the strobe, and bus release after a read. Each count is the minimum time divided by the clock period, rounded up. The defaults assume a 100 MHz clock. The controller keeps output enable high for the whole of every write. It does not switch its drivers on until the RAM has had the release time since its outputs were last enabled, so the two sides never drive the bus together.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and after it, chip select, output enable, write strobe and both lane enables are high, the data drivers are off, the memory address is zero, `rspValid` is low and `reqReady` is high.
- R2: `reqReady` is high only while the controller is idle. A request is taken on a clock edge where `reqValid` and `reqReady` are both high.
- R3: A read holds chip select and output enable low and the write strobe high for exactly ACCESS_CYC cycles, starting at the edge that takes the request. During those cycles the address is the requested one and the lane enables follow the mask: bit 0 drives `memLbN` low and gates data bits 7:0, and bit 1 drives `memUbN` low and gates data bits 15:8.
- R4: Read data is sampled at the end of the last access cycle. It is returned in the next cycle with `rspValid` high for exactly one cycle, and lanes whose mask bit is 0 read as zero.
- R5: A write holds chip select low and output enable high and drives the write data from the edge that takes the request. After WSETUP_CYC cycles the write strobe goes low for exactly WPULSE_CYC cycles.
- R6: After the strobe rises there is one more cycle in which chip select, the lane enables and the driven data stay as they were. Only then are they released and the controller goes idle.
- R7: The data drivers are never on while output enable is low. After the `rspValid` cycle of a read, the drivers stay off and `reqReady` stays low for TURN_CYC more cycles.
- R8: A write changes only the lanes whose mask bit is 1. The other lane of the same word keeps its old value.
- R9: With a mask of 0, no lane enable goes low. The write leaves memory unchanged and the read returns zero.
- R10: The write strobe is low only while chip select is low, output enable is high and the drivers are on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller idle, request can be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rspData | output | 16 | Read data, disabled lanes zero |
| rspValid | output | 1 | One-cycle read data strobe |
| memAddr | output | 16 | RAM address |
| memCeN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write strobe, active low |
| memLbN | output | 1 | Lower lane enable, active low |
| memUbN | output | 1 | Upper lane enable, active low |
| memDqOut | output | 16 | Data toward the RAM |
| memDqOe | output | 1 | Drive enable for `memDqOut` |
| memDqIn | input | 16 | Data from the RAM |

## Verification
The assertions watch the pin-level rules on every cycle:
- a low write strobe always sits inside chip select with the drivers on;
- the drivers are never on while output enable is low;
- a read keeps the strobe high;
- the strobe's rising edge leaves chip select and the drivers in place;
- `rspValid` never lasts two cycles;
- ready is only seen while the RAM is deselected.

Only the bench scenarios can show four further things: the exact cycle counts of each window, that lane masking reaches the stored words, that a masked-off lane keeps its earlier value, and that read data returns with the right value and zeroed lanes. These come from a pin-level RAM model and a behavioural expectation queue.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    IDLE,
    RD_ACCESS,
    RD_CAPTURE,
    WR_SETUP,
    WR_PULSE,
    WR_RECOVER,
    TURNAROUND
  } ctlState_e;

  // strobes from control to datapath; pin values are for the next cycle
  typedef struct packed {
    logic load;
    logic ce;
    logic oe;
    logic we;
    logic drive;
    logic capture;
  } ctlStrobe_t;

endpackage

// File: rtl/asram_ctl.sv
module asram_ctl
  import asram_pkg::*;
#(
  parameter int ACCESS_CYC = 2,
  parameter int WPULSE_CYC = 1,
  parameter int WSETUP_CYC = 1,
  parameter int TURN_CYC   = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output ctlStrobe_t strobe
);

  localparam int MAX_AB = (ACCESS_CYC > WPULSE_CYC) ? ACCESS_CYC : WPULSE_CYC;
  localparam int MAX_CD = (WSETUP_CYC > TURN_CYC) ? WSETUP_CYC : TURN_CYC;
  localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = (MAX_C > 1) ? $clog2(MAX_C) : 1;

  localparam logic [CNT_W-1:0] ACC_LD = CNT_W'(ACCESS_CYC - 1);
  localparam logic [CNT_W-1:0] WPL_LD = CNT_W'(WPULSE_CYC - 1);
  localparam logic [CNT_W-1:0] WSU_LD = CNT_W'(WSETUP_CYC - 1);
  localparam logic [CNT_W-1:0] TRN_LD = CNT_W'(TURN_CYC - 1);

  ctlState_e        state, nextState;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             cntDone;

  assign cntDone  = (cnt == '0);
  assign reqReady = (state == IDLE);

  always_comb begin
    nextState = state;
    cntNext   = cnt;
    unique case (state)
      IDLE: begin
        if (reqValid) begin
          nextState = reqWrite ? WR_SETUP : RD_ACCESS;
          cntNext   = reqWrite ? WSU_LD : ACC_LD;
        end
      end
      RD_ACCESS: begin
        if (cntDone) nextState = RD_CAPTURE;
        else         cntNext   = cnt - 1'b1;
      end
      RD_CAPTURE: begin
        nextState = TURNAROUND;
        cntNext   = TRN_LD;
      end
      TURNAROUND: begin
        if (cntDone) nextState = IDLE;
        else         cntNext   = cnt - 1'b1;
      end
      WR_SETUP: begin
        if (cntDone) begin
          nextState = WR_PULSE;
          cntNext   = WPL_LD;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      WR_PULSE: begin
        if (cntDone) nextState = WR_RECOVER;
        else         cntNext   = cnt - 1'b1;
      end
      WR_RECOVER: nextState = IDLE;
      default:    nextState = IDLE;
    endcase
  end

  always_comb begin
    strobe.load    = (state == IDLE) && reqValid;
    strobe.ce      = (nextState == RD_ACCESS) || (nextState == WR_SETUP) ||
                     (nextState == WR_PULSE)  || (nextState == WR_RECOVER);
    strobe.oe      = (nextState == RD_ACCESS);
    strobe.we      = (nextState == WR_PULSE);
    strobe.drive   = (nextState == WR_SETUP) || (nextState == WR_PULSE) ||
                     (nextState == WR_RECOVER);
    strobe.capture = (state == RD_ACCESS) && cntDone;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= cntNext;
    end
  end

endmodule

// File: rtl/asram_dp.sv
module asram_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [LANES-1:0]  memBeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic [DATA_W-1:0] rspData,
  output logic              rspValid
);

  logic [LANES-1:0]  maskQ, maskNext;
  logic [DATA_W-1:0] laneData;

  assign maskNext = strobe.load ? reqMask : maskQ;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneData[g*LANE_W +: LANE_W] = maskQ[g] ? memDqIn[g*LANE_W +: LANE_W]
                                                   : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      memAddr  <= '0;
      memCeN   <= 1'b1;
      memOeN   <= 1'b1;
      memWeN   <= 1'b1;
      memBeN   <= '1;
      memDqOut <= '0;
      memDqOe  <= 1'b0;
      maskQ    <= '0;
      rspData  <= '0;
      rspValid <= 1'b0;
    end else begin
      if (strobe.load) begin
        memAddr  <= reqAddr;
        memDqOut <= reqWdata;
        maskQ    <= reqMask;
      end
      memCeN   <= ~strobe.ce;
      memOeN   <= ~strobe.oe;
      memWeN   <= ~strobe.we;
      memBeN   <= strobe.ce ? ~maskNext : '1;
      memDqOe  <= strobe.drive;
      rspValid <= strobe.capture;
      if (strobe.capture) rspData <= laneData;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int ACCESS_CYC = 2,
  parameter int WPULSE_CYC = 1,
  parameter int WSETUP_CYC = 1,
  parameter int TURN_CYC   = 1,
  localparam int LANE_W    = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqMask,
  output logic [DATA_W-1:0] rspData,
  output logic              rspValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memLbN,
  output logic              memUbN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  ctlStrobe_t strobe;
  logic [1:0] beN;

  asram_ctl #(
    .ACCESS_CYC (ACCESS_CYC),
    .WPULSE_CYC (WPULSE_CYC),
    .WSETUP_CYC (WSETUP_CYC),
    .TURN_CYC   (TURN_CYC)
  ) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  asram_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqMask  (reqMask),
    .memDqIn  (memDqIn),
    .memAddr  (memAddr),
    .memCeN   (memCeN),
    .memOeN   (memOeN),
    .memWeN   (memWeN),
    .memBeN   (beN),
    .memDqOut (memDqOut),
    .memDqOe  (memDqOe),
    .rspData  (rspData),
    .rspValid (rspValid)
  );

  assign memLbN = beN[0];
  assign memUbN = beN[1];

endmodule

// File: rtl/asram_chk.sv
module asram_chk (
  input logic clk,
  input logic rst_n,
  input logic reqReady,
  input logic memCeN,
  input logic memOeN,
  input logic memWeN,
  input logic memDqOe,
  input logic rspValid
);

  // R2
  ready_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> memCeN);

  // R3
  read_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !memOeN |-> (memWeN && !memCeN));

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> !rspValid);

  // R5
  data_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memDqOe) |-> (memWeN && !memCeN && memOeN));

  // R6
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memWeN) |-> (!memCeN && memDqOe));

  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memDqOe |-> memOeN);

  // R7
  turn_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> !memDqOe);

  // R10
  we_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !memWeN |-> (!memCeN && memOeN && memDqOe));

endmodule

bind asram_ctrl asram_chk u_chk (.*);

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;

  localparam int ACC = 3;
  localparam int WPL = 2;
  localparam int WSU = 1;
  localparam int TRN = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic [15:0] rspData;
  logic        rspValid;
  logic [15:0] memAddr;
  logic        memCeN, memOeN, memWeN, memLbN, memUbN, memDqOe;
  logic [15:0] memDqOut;
  logic [15:0] memDqIn;

  int total = 0;
  int fail  = 0;

  always #10 clk = ~clk;

  asram_ctrl #(
    .ACCESS_CYC (ACC),
    .WPULSE_CYC (WPL),
    .WSETUP_CYC (WSU),
    .TURN_CYC   (TRN)
  ) i_asram_ctrl (.*);

  // pin-level RAM model
  logic [15:0] simMem [int];
  logic [15:0] refMem [int];

  function automatic logic [15:0] initVal(input logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] simGet(input logic [15:0] a);
    if (simMem.exists(int'(a))) return simMem[int'(a)];
    return initVal(a);
  endfunction

  function automatic logic [15:0] refGet(input logic [15:0] a);
    if (refMem.exists(int'(a))) return refMem[int'(a)];
    return initVal(a);
  endfunction

  always @* begin
    if (!memCeN && !memOeN && memWeN) begin
      memDqIn[7:0]  = memLbN ? 8'hC3 : simGet(memAddr)[7:0];
      memDqIn[15:8] = memUbN ? 8'hC3 : simGet(memAddr)[15:8];
    end else begin
      memDqIn = 16'h3C3C;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !memCeN && !memWeN) begin
      logic [15:0] v;
      v = simGet(memAddr);
      if (!memLbN) v[7:0]  = memDqOut[7:0];
      if (!memUbN) v[15:8] = memDqOut[15:8];
      simMem[int'(memAddr)] = v;
    end
    if (rst_n && !memWeN)
      chk(!memCeN && memOeN && memDqOe, "R10", "strobe gating",
          {13'd0, memCeN, memOeN, memDqOe}, 16'h0003);
  end

  // expected per-cycle behaviour
  typedef struct {
    bit          ready, ceN, oeN, weN, lbN, ubN, drv, rv;
    logic [15:0] addr, wd, rd;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  logic [15:0] curAddr = '0;

  function automatic exp_t idleExp();
    exp_t e;
    e.ready = 1; e.ceN = 1; e.oeN = 1; e.weN = 1; e.lbN = 1; e.ubN = 1;
    e.drv = 0; e.rv = 0; e.addr = curAddr; e.wd = '0; e.rd = '0; e.tag = "R2";
    return e;
  endfunction

  task automatic compareCycle();
    exp_t e;
    if (expQ.size() != 0) e = expQ.pop_front();
    else                  e = idleExp();
    chk(reqReady === e.ready, e.tag, "reqReady", 16'(reqReady), 16'(e.ready));
    chk(memCeN === e.ceN, e.tag, "memCeN", 16'(memCeN), 16'(e.ceN));
    chk(memOeN === e.oeN, e.tag, "memOeN", 16'(memOeN), 16'(e.oeN));
    chk(memWeN === e.weN, e.tag, "memWeN", 16'(memWeN), 16'(e.weN));
    chk({memUbN, memLbN} === {e.ubN, e.lbN}, e.tag, "lane enables",
        16'({memUbN, memLbN}), 16'({e.ubN, e.lbN}));
    chk(memDqOe === e.drv, e.tag, "memDqOe", 16'(memDqOe), 16'(e.drv));
    chk(rspValid === e.rv, e.tag, "rspValid", 16'(rspValid), 16'(e.rv));
    chk(memAddr === e.addr, e.tag, "memAddr", memAddr, e.addr);
    if (e.drv) chk(memDqOut === e.wd, e.tag, "memDqOut", memDqOut, e.wd);
    if (e.rv)  chk(rspData === e.rd, e.tag, "rspData", rspData, e.rd);
    chk(!(memDqOe && !memCeN && !memOeN), "R7", "bus contention",
        16'(memDqOe), 16'h0000);
  endtask

  initial begin
    wait (rst_n);
    forever begin
      @(posedge clk);
      #5;
      compareCycle();
    end
  end

  task automatic doReq(input bit wr, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] m, input string rdTag);
    exp_t e;
    logic [15:0] v;
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    curAddr = a;
    e = idleExp();
    e.ready = 0; e.ceN = 0; e.lbN = !m[0]; e.ubN = !m[1]; e.addr = a;
    if (wr) begin
      e.drv = 1; e.wd = d; e.tag = (m == 2'b00) ? "R9" : "R5";
      for (int i = 0; i < WSU; i++) expQ.push_back(e);
      e.weN = 0;
      for (int i = 0; i < WPL; i++) expQ.push_back(e);
      e.weN = 1; e.tag = "R6";
      expQ.push_back(e);
      v = refGet(a);
      if (m[0]) v[7:0]  = d[7:0];
      if (m[1]) v[15:8] = d[15:8];
      refMem[int'(a)] = v;
    end else begin
      e.oeN = 0; e.tag = (m == 2'b00) ? "R9" : "R3";
      for (int i = 0; i < ACC; i++) expQ.push_back(e);
      e = idleExp();
      e.ready = 0; e.rv = 1; e.tag = rdTag;
      v = refGet(a);
      e.rd = {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
      expQ.push_back(e);
      e.rv = 0; e.tag = "R7";
      for (int i = 0; i < TRN; i++) expQ.push_back(e);
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - fail, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fail++;
    $display("FAIL R2 watchdog: actual busy expected idle");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while reset is held
    chk({memCeN, memOeN, memWeN, memLbN, memUbN} === 5'b11111, "R1", "pins in reset",
        16'({memCeN, memOeN, memWeN, memLbN, memUbN}), 16'h001F);
    chk(memDqOe === 1'b0, "R1", "drivers in reset", 16'(memDqOe), 16'h0000);
    chk(memAddr === 16'h0000, "R1", "address in reset", memAddr, 16'h0000);
    chk(rspValid === 1'b0, "R1", "rspValid in reset", 16'(rspValid), 16'h0000);
    chk(reqReady === 1'b1, "R1", "ready in reset", 16'(reqReady), 16'h0001);
    rst_n = 1'b1;
    @(negedge clk);

    doReq(1, 16'h0010, 16'h1234, 2'b11, "R4");
    doReq(0, 16'h0010, 16'h0000, 2'b11, "R4");
    doReq(0, 16'h0020, 16'h0000, 2'b11, "R4");
    doReq(1, 16'h0010, 16'hABCD, 2'b01, "R8");
    doReq(0, 16'h0010, 16'h0000, 2'b11, "R8");
    doReq(0, 16'h0010, 16'h0000, 2'b10, "R4");
    doReq(1, 16'hFFFF, 16'h5500, 2'b10, "R8");
    doReq(0, 16'hFFFF, 16'h0000, 2'b01, "R8");
    doReq(0, 16'hFFFF, 16'h0000, 2'b11, "R8");
    doReq(1, 16'h0010, 16'hFFFF, 2'b00, "R9");
    doReq(0, 16'h0010, 16'h0000, 2'b11, "R9");
    doReq(0, 16'h0010, 16'h0000, 2'b00, "R9");
    for (int k = 0; k < 8; k++) begin
      doReq(1, 16'(16'h0100 + k * 37), 16'(16'h1111 * (k + 1)), 2'(k % 3 + 1), "R8");
      doReq(0, 16'(16'h0100 + k * 37), 16'h0000, 2'b11, "R8");
    end
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule